// File: doc/BRIEF.md
# Dual-Channel Serial DAC Input Front End

This block is the digital input side of a two-channel DAC that takes its codes over a three-wire serial link. An active-low frame strobe opens a transfer. Data bits are taken on falling edges of the serial clock, most significant bit first. Each frame holds sixteen bits. Bit 12 of the frame picks the channel, and bits 11..0 carry that channel's 12-bit code.

The block is double-buffered. A finished frame writes only the input latch of the channel it addresses. A separate active-low load strobe then moves both input latches into both output registers on the same clock. If the load strobe is held low, the addressed output register takes the new code as soon as the sixteenth bit arrives. A host that can only send bytes may split a frame into two 8-bit bursts and keep the frame strobe low between them.

All four serial inputs are sampled by the system clock, so every strobe edge is seen one clock after it happens. The serial clock must stay well below the system clock rate.

Top module: `dual_dac_front`

## Requirements
- R1: Synchronous reset (`rst` high) clears both input latches and both output registers to zero.
- R2: A frame opens on a falling edge of `sync_n`. It takes the first sixteen `sdin` bits sampled on falling `sclk` edges, most significant bit first. Bits 11..0 form the code, with bit 11 as the code MSB. Bits 15..13 have no effect.
- R3: Frame bit 12 = 0 writes channel A's input latch and bit 12 = 1 writes channel B's. The other latch keeps its value.
- R4: A frame sent as two 8-bit bursts, with `sync_n` held low and `sclk` idle between them, gives the same result as a frame sent without a break.
- R5: If `sync_n` rises before the sixteenth bit, the partial frame is dropped and no latch or output changes.
- R6: After sixteen bits, further `sclk` edges in the same frame are ignored until `sync_n` goes high and then low again.
- R7: While `load_n` stays high, a completed frame does not change `dac_a` or `dac_b`. A falling edge of `load_n` copies both input latches into both outputs on the same clock.
- R8: While `load_n` is low, a completed frame also writes its code straight into the addressed output.
- R9: An output change caused by a `load_n` fall appears on the second rising `clk` edge after the fall. One caused by the sixteenth `sclk` fall with `load_n` low appears on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Frame strobe, active low |
| sclk | input | 1 | Serial bit clock; data taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Output load strobe, active low |
| dac_a | output | 12 | Channel A output register |
| dac_b | output | 12 | Channel B output register |

## Verification
The inputs are registered once before edge detection. A `load_n` fall therefore shows on the outputs after two rising clock edges. A sixteenth `sclk` fall with `load_n` low shows after three, because the frame-done flag adds one more register. The bench drives on falling clock edges and checks those two latencies directly: it samples one edge before the update is due and then again when the update is due. Every other check waits several clocks after the stimulus has settled. Those checks compare both outputs against a bench model of the latches and outputs, which is updated only from the requirements.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CODE_W     = 12;
    localparam int SEL_POS    = 12;
    localparam int KEEP_W     = SEL_POS + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int CHANNELS   = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    // Lower part of a frame that carries meaning: the select bit and the code.
    typedef struct packed {
        chan_e chan;
        code_t code;
    } cmd_t;

    function automatic cmd_t unpack_cmd(input logic [KEEP_W-1:0] bits);
        cmd_t c;
        c.chan = chan_e'(bits[SEL_POS]);
        c.code = bits[CODE_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/dacfe_edge.sv
module dacfe_edge #(
    parameter int           N    = 3,
    parameter logic [N-1:0] IDLE = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl  <= IDLE;
            prev <= IDLE;
        end else begin
            lvl  <= pin;
            prev <= lvl;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_fall
        assign fall[i] = prev[i] & ~lvl[i];
    end

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
    import dacfe_pkg::*;
#(
    parameter int NBITS = FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             frame_open,
    input  logic             sclk_lvl,
    input  logic             sclk_fall,
    input  logic             sdin_lvl,
    output cmd_t             cmd,
    output logic             cmd_valid,
    output logic [CNT_W-1:0] bit_cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NBITS);

    logic [KEEP_W-1:0] shreg;
    logic              armed;
    logic              smp_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            armed     <= 1'b0;
            smp_bit   <= 1'b0;
            bit_cnt   <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            // hold the data value present while the clock is high
            if (sclk_lvl) begin
                smp_bit <= sdin_lvl;
            end
            if (frame_start) begin
                armed   <= 1'b1;
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (!frame_open) begin
                armed   <= 1'b0;
                bit_cnt <= '0;
            end else if (armed && sclk_fall && bit_cnt < FULL) begin
                // header bits fall off the top of the short register
                shreg   <= {shreg[KEEP_W-2:0], smp_bit};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST) begin
                    cmd_valid <= 1'b1;
                end
            end
        end
    end

    assign cmd = unpack_cmd(shreg);

endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
    import dacfe_pkg::*;
#(
    parameter int NCH = CHANNELS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  cmd_t              cmd,
    input  logic              load_lvl,
    input  logic              load_fall,
    output code_t [NCH-1:0]   lat_q,
    output code_t [NCH-1:0]   dac_q
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic hit;
        assign hit = cmd_valid && (int'(cmd.chan) == ch);

        always_ff @(posedge clk) begin
            if (rst) begin
                lat_q[ch] <= '0;
                dac_q[ch] <= '0;
            end else begin
                if (hit) begin
                    lat_q[ch] <= cmd.code;
                end
                if (hit && !load_lvl) begin
                    dac_q[ch] <= cmd.code;
                end else if (load_fall) begin
                    dac_q[ch] <= lat_q[ch];
                end
            end
        end
    end

endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              load_n,
    output logic [CODE_W-1:0] dac_a,
    output logic [CODE_W-1:0] dac_b
);

    localparam int IX_SYNC = 0;
    localparam int IX_SCLK = 1;
    localparam int IX_LOAD = 2;
    localparam int NSTROBE = 3;

    logic [NSTROBE-1:0] strobe_lvl;
    logic [NSTROBE-1:0] strobe_fall;
    logic               sdin_q;
    logic               load_lvl;
    logic               load_fall;
    cmd_t               cmd;
    logic               cmd_valid;
    logic [CNT_W-1:0]   bit_cnt;
    code_t [CHANNELS-1:0] lat_q;
    code_t [CHANNELS-1:0] dac_q;

    dacfe_edge #(.N(NSTROBE)) i_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  ({load_n, sclk, sync_n}),
        .lvl  (strobe_lvl),
        .fall (strobe_fall)
    );

    // data bit delayed to line up with the strobe samples
    always_ff @(posedge clk) begin
        if (rst) sdin_q <= 1'b0;
        else     sdin_q <= sdin;
    end

    assign load_lvl  = strobe_lvl[IX_LOAD];
    assign load_fall = strobe_fall[IX_LOAD];

    dacfe_shifter #(.NBITS(FRAME_BITS)) i_shift (
        .clk         (clk),
        .rst         (rst),
        .frame_start (strobe_fall[IX_SYNC]),
        .frame_open  (!strobe_lvl[IX_SYNC]),
        .sclk_lvl    (strobe_lvl[IX_SCLK]),
        .sclk_fall   (strobe_fall[IX_SCLK]),
        .sdin_lvl    (sdin_q),
        .cmd         (cmd),
        .cmd_valid   (cmd_valid),
        .bit_cnt     (bit_cnt)
    );

    dacfe_regs #(.NCH(CHANNELS)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .load_lvl  (load_lvl),
        .load_fall (load_fall),
        .lat_q     (lat_q),
        .dac_q     (dac_q)
    );

    assign dac_a = dac_q[0];
    assign dac_b = dac_q[1];

endmodule

// File: rtl/dacfe_checks.sv
module dacfe_checks
    import dacfe_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             load_lvl,
    input logic             load_fall,
    input logic             cmd_valid,
    input cmd_t             cmd,
    input logic [CNT_W-1:0] bit_cnt,
    input code_t            lat_a,
    input code_t            lat_b,
    input code_t            dac_a,
    input code_t            dac_b
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dac_a == '0 && dac_b == '0 && lat_a == '0 && lat_b == '0));

    // R6: the bit counter never runs past one frame
    a_r6_count_capped: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= FULL);

    // R3: a frame for one channel leaves the other latch alone
    a_r3_a_spares_b: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && cmd.chan == CH_A) |-> $stable(lat_b));

    a_r3_b_spares_a: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && cmd.chan == CH_B) |-> $stable(lat_a));

    // R7: outputs move only on a load fall or a finished frame
    a_r7_a_moves_on_event: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_a) |-> $past(load_fall || cmd_valid));

    a_r7_b_moves_on_event: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_b) |-> $past(load_fall || cmd_valid));

    // R7: a load fall copies both latches together
    a_r7_copy_both: assert property (@(posedge clk) disable iff (rst)
        $past(load_fall && !cmd_valid) |-> (dac_a == $past(lat_a) && dac_b == $past(lat_b)));

    // R8: load held low writes the addressed output at once
    a_r8_direct_a: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && !load_lvl && cmd.chan == CH_A) |-> dac_a == $past(cmd.code));

    a_r8_direct_b: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && !load_lvl && cmd.chan == CH_B) |-> dac_b == $past(cmd.code));

endmodule

bind dual_dac_front dacfe_checks i_checks (
    .clk       (clk),
    .rst       (rst),
    .load_lvl  (load_lvl),
    .load_fall (load_fall),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .bit_cnt   (bit_cnt),
    .lat_a     (lat_q[0]),
    .lat_b     (lat_q[1]),
    .dac_a     (dac_a),
    .dac_b     (dac_b)
);

// File: tb/test_dual_dac_front.sv
module test_dual_dac_front;

    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        sync_n;
    logic        sclk;
    logic        sdin;
    logic        load_n;
    logic [11:0] dac_a;
    logic [11:0] dac_b;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [11:0] m_lat [2];
    logic [11:0] m_dac [2];

    always #5 clk = ~clk;

    dual_dac_front i_dual_dac_front (
        .clk    (clk),
        .rst    (rst),
        .sync_n (sync_n),
        .sclk   (sclk),
        .sdin   (sdin),
        .load_n (load_n),
        .dac_a  (dac_a),
        .dac_b  (dac_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_both(input string req);
        check({req, " dac_a"}, dac_a, m_dac[0]);
        check({req, " dac_b"}, dac_b, m_dac[1]);
    endtask

    task automatic clk_bit(input logic b);
        sclk = 1'b1;
        sdin = b;
        tick(HALF);
        sclk = 1'b0;
        tick(HALF);
    endtask

    // model: frame complete
    task automatic model_frame(input logic [15:0] w);
        int s;
        s = int'(w[12]);
        m_lat[s] = w[11:0];
        if (!load_n) m_dac[s] = w[11:0];
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input bit burst);
        sync_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            clk_bit(i < 16 ? w[15 - (i % 16)] : 1'b1);
            if (burst && i == 7) tick(10);
        end
        tick(HALF);
        sync_n = 1'b1;
        tick(HALF);
        if (nbits >= 16) model_frame(w);
    endtask

    task automatic pulse_load;
        load_n = 1'b0;
        m_dac[0] = m_lat[0];
        m_dac[1] = m_lat[1];
        tick(HALF);
        load_n = 1'b1;
        tick(HALF);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [15:0] w;
        int          mode;
        void'($urandom(32'd20240611));
        rst = 1'b1; sync_n = 1'b1; sclk = 1'b0; sdin = 1'b0; load_n = 1'b1;
        m_lat[0] = '0; m_lat[1] = '0; m_dac[0] = '0; m_dac[1] = '0;
        tick(4);
        rst = 1'b0;
        tick(2);
        check_both("R1 reset");
        pulse_load();
        check_both("R1 latches zero");

        // R2 R3: header 111 ignored, channel A
        send(16'hEABC, 16, 1'b0);
        check_both("R7 no change before load");
        pulse_load();
        check_both("R2 code A");

        // R3: channel B
        send(16'h1123, 16, 1'b0);
        check_both("R3 B not yet loaded");
        pulse_load();
        check_both("R3 code B");

        // R7 R9: both together, load latency two edges
        send(16'h0555, 16, 1'b0);
        send(16'hFAAA, 16, 1'b0);
        load_n = 1'b0;
        tick(1);
        check_both("R9 load not before second edge");
        m_dac[0] = m_lat[0];
        m_dac[1] = m_lat[1];
        tick(1);
        check_both("R7 R9 both loaded together");
        load_n = 1'b1;
        tick(HALF);

        // R4: two bursts
        send(16'h0F0F, 16, 1'b1);
        pulse_load();
        check_both("R4 burst frame");

        // R5: aborted frames
        send(16'h0777, 10, 1'b0);
        send(16'h1888, 15, 1'b0);
        pulse_load();
        check_both("R5 partial dropped");

        // R6: extra clock edges after sixteen bits
        send(16'h1333, 20, 1'b0);
        pulse_load();
        check_both("R6 extra bits ignored");

        // R8 R9: load held low, direct write on sixteenth fall
        load_n = 1'b0;
        m_dac[0] = m_lat[0];
        m_dac[1] = m_lat[1];
        tick(HALF);
        w = 16'h0246;
        sync_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < 15; i++) clk_bit(w[15 - i]);
        sclk = 1'b1;
        sdin = w[0];
        tick(HALF);
        sclk = 1'b0;
        tick(2);
        check_both("R9 direct not before third edge");
        tick(1);
        model_frame(w);
        check_both("R8 R9 direct write A");
        tick(HALF);
        sync_n = 1'b1;
        tick(HALF);
        load_n = 1'b1;
        tick(HALF);
        check_both("R8 load release no change");

        // random mix
        for (int it = 0; it < 60; it++) begin
            w    = 16'($urandom);
            mode = int'($urandom % 6);
            case (mode)
                0: send(w, 16, 1'b0);
                1: send(w, 16, 1'b1);
                2: send(w, int'($urandom % 16), 1'b0);
                3: send(w, 17 + int'($urandom % 6), 1'b0);
                4: pulse_load();
                default: begin
                    load_n = 1'b0;
                    m_dac[0] = m_lat[0];
                    m_dac[1] = m_lat[1];
                    tick(HALF);
                    send(w, 16, 1'b0);
                    load_n = 1'b1;
                    tick(HALF);
                end
            endcase
            check_both("R2 R3 R5 R6 R7 R8 random");
        end
        pulse_load();
        check_both("R7 final load");
        summary();
    end

endmodule